// File: doc/BRIEF.md
# Multi-Digit Decimal (BCD) Adder

This block adds two unsigned decimal numbers, each held as packed binary-coded-decimal digits, together with a one-bit carry input. It returns a packed decimal sum of the same width and a decimal carry out. Each digit has its own slice. A slice first forms the plain 4-bit binary sum of its two digits and the incoming carry. When that sum cannot stand as a decimal digit, the slice adds six to skip the six unused codes. The decimal carry of each slice feeds the next more significant slice, so the carry ripples from the lowest digit to the highest.

A screening path raises a flag whenever any digit of either operand holds a code above nine. The sum is still produced by the same slice rules in that case. A parameter places either one register stage or none after the arithmetic. The registered form has a synchronous active-high reset and a valid flag that trails the input valid by one clock.

Top module: `bcd_chain_adder`

## Requirements
- R1: When a slice's binary sum of its two digits and carry in is at most nine with no binary carry, the result digit equals that sum and the slice's decimal carry is 0 (3+5 gives 8, carry 0).
- R2: When a slice's 4-bit binary sum is one of the codes 10 to 15 and there is no binary carry, the result digit is the low 4 bits of that sum plus six, and the decimal carry is 1 (8+5 gives 3 carry 1; 9+3 gives 2 carry 1).
- R3: When a slice's binary addition carries out of 4 bits, six is added to the low 4 bits, and the decimal carry is 1 (8+9 gives 7 carry 1; 9+7 gives 6 carry 1).
- R4: A slice's decimal carry is 1 exactly when the six correction was applied. Any carry out of the correction addition is dropped.
- R5: `carry_in` enters the least significant digit. Each slice's decimal carry enters the next higher digit. `carry_out` is the decimal carry of the most significant digit.
- R6: Operands and sum are packed as NDIG 4-bit digits. Digit k occupies bits [4k+3:4k], so the least significant digit is in bits [3:0].
- R7: `bad_digit` is 1 exactly when some digit of `a_in` or `b_in` exceeds 9. The sum and carry are still formed by R1 to R4 for such inputs (a digit of 15 added to 0 gives digit 5 carry 1).
- R8: With REGISTERED=1, `sum_out`, `carry_out` and `bad_digit` show the result of the inputs present at the previous rising clock edge, and `out_valid` equals `in_valid` from that edge.
- R9: With REGISTERED=1, a cycle with `rst` high makes `sum_out`, `carry_out`, `bad_digit` and `out_valid` all 0 after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the operands as meaningful |
| a_in | input | 4*NDIG | First packed decimal operand |
| b_in | input | 4*NDIG | Second packed decimal operand |
| carry_in | input | 1 | Carry into the least significant digit |
| sum_out | output | 4*NDIG | Packed decimal sum |
| carry_out | output | 1 | Decimal carry out of the top digit |
| bad_digit | output | 1 | Some operand digit exceeds 9 |
| out_valid | output | 1 | Qualifies the outputs |

## Verification
The stimulus targets the two separate reasons for correction. A slice with a 4-bit sum from 10 to 15 and a slice that overflows 4 bits, such as 8+9, both need the fix. A design that tested only the 4-bit sum would return 1 instead of 7 for 8+9. A design that took its carry from the correction adder would lose that carry.

Other cases check the ripple path. Long carry runs such as 9999+0001 and 9999+9999 with carry in would show a carry that is dropped or sent to the wrong digit. Inputs such as 1234+5678 and 4321+0 would show reversed digit ordering.

Illegal digits in the top, middle and bottom positions must raise the flag while the sum still follows the slice rules. The bench also checks the single-cycle latency, the valid tracking and a reset in the middle of a run.

// File: rtl/bcd_add_pkg.sv
package bcd_add_pkg;

    localparam int DIGIT_W = 4;
    localparam logic [DIGIT_W-1:0] DEC_MAX = 4'd9;
    localparam logic [DIGIT_W-1:0] SKIP_SIX = 4'd6;

    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t value;
        logic   carry;
    } slice_res_t;

    // correction is due on a binary carry or on codes 1010..1111
    function automatic logic needs_adjust(input logic raw_carry, input digit_t z);
        return raw_carry | (z[3] & z[2]) | (z[3] & z[1]);
    endfunction

    function automatic logic digit_illegal(input digit_t d);
        return d > DEC_MAX;
    endfunction

endpackage

// File: rtl/bcd_digit_slice.sv
module bcd_digit_slice
    import bcd_add_pkg::*;
(
    input  digit_t     op_a,
    input  digit_t     op_b,
    input  logic       carry_i,
    output slice_res_t res
);
    logic [DIGIT_W:0] raw_sum;
    logic             adjust;
    digit_t           fixed;

    always_comb begin
        raw_sum = {1'b0, op_a} + {1'b0, op_b} + {{DIGIT_W{1'b0}}, carry_i};
        adjust  = needs_adjust(raw_sum[DIGIT_W], raw_sum[DIGIT_W-1:0]);
        // 4-bit wide add: the correction's own carry falls away
        fixed   = raw_sum[DIGIT_W-1:0] + (adjust ? SKIP_SIX : '0);
        res.value = fixed;
        res.carry = adjust;
    end
endmodule

// File: rtl/bcd_digit_screen.sv
module bcd_digit_screen
    import bcd_add_pkg::*;
#(
    parameter int NDIG = 4,
    localparam int W = NDIG * DIGIT_W
)(
    input  logic [W-1:0] a_vec,
    input  logic [W-1:0] b_vec,
    output logic         any_bad
);
    logic [NDIG-1:0] bad_a;
    logic [NDIG-1:0] bad_b;

    for (genvar k = 0; k < NDIG; k++) begin : g_scan
        assign bad_a[k] = digit_illegal(a_vec[k*DIGIT_W +: DIGIT_W]);
        assign bad_b[k] = digit_illegal(b_vec[k*DIGIT_W +: DIGIT_W]);
    end

    assign any_bad = |{bad_a, bad_b};
endmodule

// File: rtl/bcd_out_stage.sv
module bcd_out_stage #(
    parameter int WIDTH      = 18,
    parameter bit REGISTERED = 1'b1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             d_valid,
    input  logic [WIDTH-1:0] d,
    output logic             q_valid,
    output logic [WIDTH-1:0] q
);
    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q       <= '0;
                q_valid <= 1'b0;
            end else begin
                q       <= d;
                q_valid <= d_valid;
            end
        end
    end else begin : g_comb
        assign q       = d;
        assign q_valid = d_valid;
    end
endmodule

// File: rtl/bcd_chain_adder.sv
module bcd_chain_adder
    import bcd_add_pkg::*;
#(
    parameter int NDIG       = 4,
    parameter bit REGISTERED = 1'b1,
    localparam int W = NDIG * DIGIT_W
)(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         carry_in,
    output logic [W-1:0] sum_out,
    output logic         carry_out,
    output logic         bad_digit,
    output logic         out_valid
);
    localparam int PACK_W = W + 2;

    logic [NDIG:0]       chain;
    slice_res_t          slice_res [NDIG];
    logic [W-1:0]        sum_comb;
    logic                bad_comb;
    logic [PACK_W-1:0]   stage_d;
    logic [PACK_W-1:0]   stage_q;

    assign chain[0] = carry_in;

    for (genvar k = 0; k < NDIG; k++) begin : g_digit
        bcd_digit_slice u_slice (
            .op_a    (a_in[k*DIGIT_W +: DIGIT_W]),
            .op_b    (b_in[k*DIGIT_W +: DIGIT_W]),
            .carry_i (chain[k]),
            .res     (slice_res[k])
        );
        assign sum_comb[k*DIGIT_W +: DIGIT_W] = slice_res[k].value;
        assign chain[k+1] = slice_res[k].carry;
    end

    bcd_digit_screen #(.NDIG(NDIG)) u_screen (
        .a_vec   (a_in),
        .b_vec   (b_in),
        .any_bad (bad_comb)
    );

    assign stage_d = {bad_comb, chain[NDIG], sum_comb};

    bcd_out_stage #(.WIDTH(PACK_W), .REGISTERED(REGISTERED)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .d_valid (in_valid),
        .d       (stage_d),
        .q_valid (out_valid),
        .q       (stage_q)
    );

    assign {bad_digit, carry_out, sum_out} = stage_q;
endmodule

// File: rtl/bcd_chain_adder_chk.sv
module bcd_chain_adder_chk
    import bcd_add_pkg::*;
#(
    parameter int NDIG       = 4,
    parameter bit REGISTERED = 1'b1,
    localparam int W = NDIG * DIGIT_W
)(
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         carry_in,
    input logic [W-1:0] sum_out,
    input logic         carry_out,
    input logic         bad_digit,
    input logic         out_valid
);
    logic         src_valid;
    logic [W-1:0] src_a;
    logic [W-1:0] src_b;
    logic         src_cin;

    if (REGISTERED) begin : g_delay
        always_ff @(posedge clk) begin
            if (rst) begin
                src_valid <= 1'b0;
                src_a     <= '0;
                src_b     <= '0;
                src_cin   <= 1'b0;
            end else begin
                src_valid <= in_valid;
                src_a     <= a_in;
                src_b     <= b_in;
                src_cin   <= carry_in;
            end
        end
    end else begin : g_direct
        assign src_valid = in_valid;
        assign src_a     = a_in;
        assign src_b     = b_in;
        assign src_cin   = carry_in;
    end

    logic src_any_bad;
    logic src_all_nine;
    logic out_all_dec;

    always_comb begin
        src_any_bad  = 1'b0;
        src_all_nine = 1'b1;
        out_all_dec  = 1'b1;
        for (int k = 0; k < NDIG; k++) begin
            if (src_a[k*4 +: 4] > 4'd9 || src_b[k*4 +: 4] > 4'd9) src_any_bad = 1'b1;
            if (src_a[k*4 +: 4] != 4'd9) src_all_nine = 1'b0;
            if (sum_out[k*4 +: 4] > 4'd9) out_all_dec = 1'b0;
        end
    end

    p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid == src_valid);

    p_clean_digits_r1: assert property (@(posedge clk) disable iff (rst)
        !bad_digit |-> out_all_dec);

    p_bad_flag_r7: assert property (@(posedge clk) disable iff (rst)
        bad_digit == src_any_bad);

    p_full_ripple_r5: assert property (@(posedge clk) disable iff (rst)
        (src_all_nine && src_b == '0 && src_cin) |-> (sum_out == '0 && carry_out));

    p_zero_sum_r1: assert property (@(posedge clk) disable iff (rst)
        (src_a == '0 && src_b == '0 && !src_cin) |-> (sum_out == '0 && !carry_out));
endmodule

bind bcd_chain_adder bcd_chain_adder_chk #(.NDIG(NDIG), .REGISTERED(REGISTERED)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .bad_digit (bad_digit),
    .out_valid (out_valid)
);

// File: tb/bcd_chain_adder_tb.sv
module bcd_chain_adder_tb;
    localparam int NDIG = 4;
    localparam int W = NDIG * 4;
    localparam time CLK_P = 10ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    logic         bad_digit;
    logic         out_valid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bcd_chain_adder #(.NDIG(NDIG), .REGISTERED(1'b1)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a_in(a_in), .b_in(b_in),
        .carry_in(carry_in), .sum_out(sum_out), .carry_out(carry_out),
        .bad_digit(bad_digit), .out_valid(out_valid)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [15:0] s;
        logic        co;
        logic        bad;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{16'h0003, 16'h0005, 1'b0, 16'h0008, 1'b0, 1'b0},  // R1 3+5
        '{16'h0008, 16'h0005, 1'b0, 16'h0013, 1'b0, 1'b0},  // R2 8+5
        '{16'h0008, 16'h0009, 1'b0, 16'h0017, 1'b0, 1'b0},  // R3 8+9
        '{16'h0009, 16'h0007, 1'b0, 16'h0016, 1'b0, 1'b0},  // R3 9+7
        '{16'h0009, 16'h0003, 1'b0, 16'h0012, 1'b0, 1'b0},  // R2 9+3
        '{16'h9999, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0},  // R5 ripple
        '{16'h9999, 16'h9999, 1'b1, 16'h9999, 1'b1, 1'b0},  // R4 carry equals correction
        '{16'h1234, 16'h5678, 1'b0, 16'h6912, 1'b0, 1'b0},  // R6 ordering
        '{16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0},  // R5 carry_in
        '{16'h4321, 16'h0000, 1'b0, 16'h4321, 1'b0, 1'b0},  // R6 digit positions
        '{16'h000F, 16'h0000, 1'b0, 16'h0015, 1'b0, 1'b1},  // R7 low illegal digit
        '{16'hA000, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1},  // R7 top illegal digit
        '{16'h0000, 16'h00B0, 1'b0, 16'h0110, 1'b0, 1'b1},  // R7 middle illegal in b
        '{16'h5000, 16'h5000, 1'b0, 16'h0000, 1'b1, 1'b0},  // R2 top digit ten
        '{16'h0505, 16'h0505, 1'b0, 16'h1010, 1'b0, 1'b0}   // R2 alternating
    };

    task automatic check(input string tag, input logic [W+2:0] act, input logic [W+2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic vld);
        @(negedge clk);
        a_in = v.a; b_in = v.b; carry_in = v.cin; in_valid = vld;
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset outputs", {out_valid, bad_digit, carry_out, sum_out}, '0);
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7 via table, R8 one-cycle latency
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i], 1'b1);
            @(negedge clk);
            check($sformatf("R1-table vector %0d (R2 R3 R4 R5 R6 R7)", i),
                  {out_valid, bad_digit, carry_out, sum_out},
                  {1'b1, VECS[i].bad, VECS[i].co, VECS[i].s});
        end

        // R8 out_valid follows a low in_valid
        apply(VECS[1], 1'b0);
        @(negedge clk);
        check("R8 valid low", {3'b000, 16'h0000} | {out_valid, 18'h0}, '0);
        check("R8 data with valid low", {1'b0, bad_digit, carry_out, sum_out}, {3'b000, 16'h0013});

        // R8 output holds the prior result until the next edge
        apply(VECS[2], 1'b1);
        #1;
        check("R8 before edge", {out_valid, bad_digit, carry_out, sum_out}, {3'b000, 16'h0013});
        @(negedge clk);
        check("R8 after edge", {out_valid, bad_digit, carry_out, sum_out}, {3'b100, 16'h0017});

        // R9 reset in mid-run clears registered outputs
        apply(VECS[11], 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid-run reset", {out_valid, bad_digit, carry_out, sum_out}, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R7 after reset", {out_valid, bad_digit, carry_out, sum_out}, {3'b111, 16'h0000});

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule